// File: doc/BRIEF.md
# Receive Drop Statistics Register

This block counts receive frames that a DMA receive path had to throw away and reports the counts in one read-only 32-bit status word. The word resets to zero and clears when it is read. It holds two counters. The first counts frames dropped because no receive descriptor was free. The second counts frames lost to receive FIFO overflow, together with good frames shorter than 64 bytes (runts). Each counter has a sticky overflow flag that records a wrap since the last read.

Event inputs are single-cycle pulses. The DMA raises `nodesc_drop_i` when it discards a frame. The receive FIFO logic raises `fifo_ovf_drop_i` on an overflow loss. It raises `runt_drop_i` only for a frame that ended with good status and a byte count below 64, so a frame of 64 bytes or more never produces a runt pulse. Software or a register bus reads the word with a strobe and an address. The data appears on `rd_data_o` one clock after the strobe and stays there until the next strobe.

Top module: `rx_drop_stat_reg`

## Requirements
- R1: While reset is asserted and after it is released, `rd_data_o` is zero and both counters and both overflow flags are zero.
- R2: Bits 15:0 of the word count `nodesc_drop_i` pulses, one per pulse.
- R3: Bits 27:17 of the word count frames lost to FIFO overflow or runt status. A cycle with both `fifo_ovf_drop_i` and `runt_drop_i` high adds two.
- R4: When a counter passes its maximum value it wraps modulo its size, and its overflow flag (bit 16 for the 16-bit counter, bit 28 for the 11-bit counter) sets. The flag stays set until the next read.
- R5: A cycle with `rd_en_i` high and `rd_addr_i` equal to 0x1020 loads the current word into `rd_data_o` on the next clock and clears both counters and both flags. Without a strobe, `rd_data_o` and the counters do not change.
- R6: An event in the same cycle as a clearing read is not part of the returned word. After the clear, the counter holds that event (1, or 2 for a double FIFO/runt event).
- R7: Bits 31:29 of the word always read as zero.
- R8: A strobe to any other address leaves both counters and both flags unchanged and loads zero into `rd_data_o`.
- R9: The two counters update independently when events for both arrive in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| nodesc_drop_i | input | 1 | Pulse: frame discarded, no receive descriptor free |
| fifo_ovf_drop_i | input | 1 | Pulse: frame lost to receive FIFO overflow |
| runt_drop_i | input | 1 | Pulse: good frame below 64 bytes dropped |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 16 | Read address offset |
| rd_data_o | output | 32 | Read data, valid the cycle after the strobe |

## Verification
The bench drives the 16-bit counter through a full wrap, to 1 with its flag set. A design that saturated, or that dropped the flag, would return the wrong count or a clear bit 16. It pushes the 11-bit counter across its limit with double events, which a design that added only one per cycle would miss. It reads on the same cycle as events, where a design that cleared after adding would lose the event or report it early. It reads other addresses, which a loose decode would turn into a clear.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned ADDR_W       = 16;
  localparam logic [15:0] REG_OFFSET   = 16'h1020;
  localparam int unsigned NODESC_CNT_W = 16;
  localparam int unsigned FIFO_CNT_W   = 11;
  localparam int unsigned FIFO_INC_W   = 2;
endpackage

// File: rtl/rxstat_event_counter.sv
module rxstat_event_counter #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned INC_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             wrap_o
);
  localparam int unsigned SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // carry-extended add; the top bit is the wrap event
  function automatic logic [SUM_W-1:0] add_wide(input logic [CNT_W-1:0] base,
                                                input logic [INC_W-1:0] inc);
    return {1'b0, base} + SUM_W'(inc);
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic [CNT_W-1:0] base_c;
  logic [SUM_W-1:0] sum_c;
  logic             wrap_c;

  assign base_c = clr_i ? '0 : cnt_q;
  assign sum_c  = add_wide(base_c, inc_i);
  assign wrap_c = sum_c[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= sum_c[CNT_W-1:0];
      ovf_q <= (ovf_q & ~clr_i) | wrap_c;
    end
  end

  assign cnt_o  = cnt_q;
  assign ovf_o  = ovf_q;
  assign wrap_o = wrap_c;

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_i) |=> ovf_q);

  // R4
  max_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && inc_i != '0 && !clr_i) |=>
      (ovf_q && cnt_q == CNT_W'($past(inc_i)) - CNT_W'(1)));

  // R5
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i == '0 && !clr_i) |=> ($stable(cnt_q) && $stable(ovf_q)));

  // R6
  clr_keeps_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == CNT_W'($past(inc_i)) && !ovf_q));
endmodule

// File: rtl/rxstat_read_port.sv
module rxstat_read_port #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFFSET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] data_q;

  assign hit_o = rd_en_i && (rd_addr_i == OFFSET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (rd_en_i) begin
      data_q <= hit_o ? word_i : '0;
    end
  end

  assign rd_data_o = data_q;

  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !hit_o) |=> (rd_data_o == '0));

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/rx_drop_stat_reg.sv
module rx_drop_stat_reg
  import rxstat_pkg::*;
#(
  parameter int unsigned NODESC_W = NODESC_CNT_W,
  parameter int unsigned FIFO_W   = FIFO_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nodesc_drop_i,
  input  logic              fifo_ovf_drop_i,
  input  logic              runt_drop_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned NODESC_OVF_BIT = NODESC_W;
  localparam int unsigned FIFO_LSB       = NODESC_W + 1;
  localparam int unsigned FIFO_OVF_BIT   = FIFO_LSB + FIFO_W;
  localparam int unsigned RSV_W          = DATA_W - FIFO_OVF_BIT - 1;

  logic                  rd_hit;
  logic [FIFO_INC_W-1:0] fifo_inc;
  logic [NODESC_W-1:0]   nodesc_cnt;
  logic                  nodesc_ovf;
  logic                  nodesc_wrap;
  logic [FIFO_W-1:0]     fifo_cnt;
  logic                  fifo_ovf;
  logic                  fifo_wrap;
  logic [DATA_W-1:0]     word;

  assign fifo_inc = FIFO_INC_W'(fifo_ovf_drop_i) + FIFO_INC_W'(runt_drop_i);

  rxstat_event_counter #(.CNT_W(NODESC_W), .INC_W(1)) u_nodesc (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (nodesc_drop_i),
    .clr_i  (rd_hit),
    .cnt_o  (nodesc_cnt),
    .ovf_o  (nodesc_ovf),
    .wrap_o (nodesc_wrap)
  );

  rxstat_event_counter #(.CNT_W(FIFO_W), .INC_W(FIFO_INC_W)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (fifo_inc),
    .clr_i  (rd_hit),
    .cnt_o  (fifo_cnt),
    .ovf_o  (fifo_ovf),
    .wrap_o (fifo_wrap)
  );

  assign word[NODESC_W-1:0]           = nodesc_cnt;
  assign word[NODESC_OVF_BIT]         = nodesc_ovf;
  assign word[FIFO_OVF_BIT-1:FIFO_LSB] = fifo_cnt;
  assign word[FIFO_OVF_BIT]           = fifo_ovf;

  generate
    if (RSV_W > 0) begin : g_rsv
      assign word[DATA_W-1:FIFO_OVF_BIT+1] = '0;
    end
  endgenerate

  rxstat_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(REG_OFFSET)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .word_i    (word),
    .hit_o     (rd_hit),
    .rd_data_o (rd_data_o)
  );

  // R5
  clear_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> (nodesc_cnt <= NODESC_W'(1) && fifo_cnt <= FIFO_W'(2)
                && !nodesc_ovf && !fifo_ovf));

  // R8
  miss_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_hit && !nodesc_drop_i && !fifo_ovf_drop_i && !runt_drop_i) |=>
      ($stable(nodesc_cnt) && $stable(fifo_cnt) && $stable(nodesc_ovf) && $stable(fifo_ovf)));

  // R9
  nodesc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nodesc_wrap && !fifo_wrap && !rd_hit && !fifo_ovf) |=> !fifo_ovf);
endmodule

// File: tb/sim_rx_drop_stat_reg.sv
`timescale 1ns/1ps
module sim_rx_drop_stat_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nd_i = 1'b0, fo_i = 1'b0, rn_i = 1'b0, rd_i = 1'b0;
  logic [15:0] addr_i = 16'h0;
  logic [31:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int nd = 0, ndo = 0, fc = 0, fco = 0;
  logic [31:0] exp_rd = 32'h0;

  localparam logic [15:0] OFS = 16'h1020;

  always #2 clk = ~clk;

  rx_drop_stat_reg u0 (
    .clk(clk), .rst_n(rst_n), .nodesc_drop_i(nd_i), .fifo_ovf_drop_i(fo_i),
    .runt_drop_i(rn_i), .rd_en_i(rd_i), .rd_addr_i(addr_i), .rd_data_o(rd_data_o)
  );

  function automatic logic [31:0] pack_word();
    return (32'(fco) << 28) | (32'(fc) << 17) | (32'(ndo) << 16) | 32'(nd);
  endfunction

  task automatic check(input string tag);
    checks++;
    if (rd_data_o !== exp_rd) begin
      errors++;
      $display("FAIL %s: rd_data actual %h expected %h", tag, rd_data_o, exp_rd);
    end
  endtask

  task automatic cyc(input bit nd_e, input bit fo_e, input bit rn_e, input bit rd_e,
                     input logic [15:0] a, input string tag);
    nd_i = nd_e; fo_i = fo_e; rn_i = rn_e; rd_i = rd_e; addr_i = a;
    @(posedge clk);
    if (rd_e) begin
      exp_rd = (a == OFS) ? pack_word() : 32'h0;
      if (a == OFS) begin nd = 0; ndo = 0; fc = 0; fco = 0; end
    end
    nd = nd + int'(nd_e);
    if (nd > 65535) begin nd = nd - 65536; ndo = 1; end
    fc = fc + int'(fo_e) + int'(rn_e);
    if (fc > 2047) begin fc = fc - 2048; fco = 1; end
    @(negedge clk);
    check(tag);
  endtask

  task automatic rd_reg(input string tag);
    cyc(0, 0, 0, 1, OFS, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) begin @(negedge clk); check("R1"); end
    rst_n = 1'b1;
    @(negedge clk); check("R1");
    rd_reg("R1");
    // R2 single counter
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 16'h0, "R2");
    rd_reg("R2");
    // R3 fifo overflow, runt, and both together
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 16'h0, "R3");
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 16'h0, "R3");
    for (int i = 0; i < 2; i++) cyc(0, 1, 1, 0, 16'h0, "R3");
    rd_reg("R3");
    // R9 both counters in same cycle
    for (int i = 0; i < 6; i++) cyc(1, i[0], 1, 0, 16'h0, "R9");
    rd_reg("R9");
    // R8 read elsewhere: zero data, counts kept
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 16'h0, "R8");
    cyc(0, 0, 0, 1, 16'h1024, "R8");
    cyc(0, 0, 0, 1, 16'h0020, "R8");
    cyc(0, 0, 0, 0, 16'h1020, "R8");
    rd_reg("R8");
    // R6 events coincident with read
    cyc(1, 1, 1, 0, 16'h0, "R6");
    cyc(1, 1, 1, 1, OFS, "R6");
    rd_reg("R6");
    // R4 16-bit wrap to 1 with sticky flag
    for (int i = 0; i < 65537; i++) cyc(1, 0, 0, 0, 16'h0, "R4");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 16'h0, "R4");
    rd_reg("R4");
    if (rd_data_o[16] !== 1'b1 || rd_data_o[15:0] !== 16'd1) begin
      errors++;
      $display("FAIL R4: word actual %h expected count 1 with bit16 set", rd_data_o);
    end
    checks++;
    rd_reg("R4");
    // R4 11-bit wrap by double events, then one more
    for (int i = 0; i < 1024; i++) cyc(0, 1, 1, 0, 16'h0, "R4");
    cyc(0, 1, 0, 0, 16'h0, "R4");
    rd_reg("R4");
    // R7 reserved bits zero with all fields active
    for (int i = 0; i < 1024; i++) cyc(1, 1, 1, 0, 16'h0, "R7");
    rd_reg("R7");
    checks++;
    if (rd_data_o[31:29] !== 3'b000) begin
      errors++;
      $display("FAIL R7: reserved actual %b expected 000", rd_data_o[31:29]);
    end
    rd_reg("R5");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 16'h0, "R5");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule